// File: doc/BRIEF.md
# Completion Pointer Interrupt Controller

This block raises per-channel interrupts for a multi-channel DMA engine that reports finished packets by address. When the DMA side finishes a packet on a channel, it hands over the address of that packet's last descriptor. The block stores that address as the channel's completion pointer and marks the channel pending. The host reads the pointer and works through its descriptor chain. It then returns the address of the last descriptor it handled on a separate acknowledge stream. The pending bit drops only when the returned address matches the stored pointer. A stale or partial acknowledge therefore leaves the interrupt asserted.

Completions and acknowledges arrive as valid/ready streams. A beat is taken on any cycle where valid and ready are both high. Ready is held high whenever the block is out of reset, so neither stream ever sees back-pressure. The upstream side may hold valid high for consecutive beats. An enable mask gates the pending bits onto the level interrupt outputs. Software changes the mask through separate set and clear write addresses. Software reads the mask, the raw and masked status, and every pointer through a plain register port that answers combinationally.

Top module: `cmpl_irq_ctrl`

## Requirements
- R1: After reset every completion pointer reads 0, and raw status, masked status, mask, `irq` and `irq_any` are all 0.
- R2: A pending channel stays pending, with its interrupt level held, through any number of cycles and through acknowledges whose address differs from its stored pointer.
- R3: A register write to address 0x00 sets the mask bits that are 1 in `reg_wdata`. A write to address 0x01 clears the mask bits that are 1. Bits written as 0 leave the mask unchanged. The mask reads at address 0x02, with bit i belonging to channel i.
- R4: Raw pending status reads at address 0x03 and masked status (raw AND mask) reads at address 0x04. Each is an 8-bit word with bit i belonging to channel i.
- R5: An accepted completion beat on channel c stores `post_addr` into pointer c and sets channel c pending from the next cycle on, whatever the address value, zero included.
- R6: Pointer c reads at address 0x10+c and returns the last address posted on channel c. An acknowledge never modifies any pointer.
- R7: An acknowledge on channel c whose address equals pointer c clears channel c pending from the next cycle. After several completions, only the most recently posted address clears the channel.
- R8: When a completion and a matching acknowledge hit the same channel in the same cycle, the completion wins: the pointer takes the new address and the channel stays pending.
- R9: `irq[i]` is pending bit i AND mask bit i, and `irq_any` is the OR of all `irq` bits. Changing the mask never alters raw pending status.
- R10: `post_ready` and `ack_ready` are 1 whenever `rst_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| post_valid | input | 1 | Completion beat valid |
| post_ready | output | 1 | Completion beat accepted |
| post_chan | input | 3 | Channel of the completion |
| post_addr | input | 32 | Last descriptor address of the completed packet |
| ack_valid | input | 1 | Host acknowledge valid |
| ack_ready | output | 1 | Host acknowledge accepted |
| ack_chan | input | 3 | Channel being acknowledged |
| ack_addr | input | 32 | Last descriptor address processed by the host |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 8 | Per-channel level interrupts |
| irq_any | output | 1 | OR of all channel interrupts |

## Verification
The bench builds the block with its defaults: eight channels and 32-bit pointers. At this size the lowest and highest channels, channel 0 and channel 7, can both be driven. The stored addresses can reach both extremes, all zeros and all ones, so a completion written with address zero is distinguishable from the reset state only through the pending bit. The pointer read window at 0x10 through 0x17 covers every channel, so each read address is decoded against a real pointer.

// File: rtl/cmpl_irq_pkg.sv
package cmpl_irq_pkg;
  localparam int REG_AW = 5;

  typedef enum logic [REG_AW-1:0] {
    RA_MASK_SET = 5'h00,
    RA_MASK_CLR = 5'h01,
    RA_MASK     = 5'h02,
    RA_RAW      = 5'h03,
    RA_MASKED   = 5'h04
  } reg_addr_e;

  // Pointer window: bit 4 set, channel in the low bits
  localparam int PTR_SEL_BIT = 4;
endpackage

// File: rtl/cmpl_ptr_chan.sv
module cmpl_ptr_chan #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post_hit,
  input  logic [ADDR_W-1:0] post_addr,
  input  logic              ack_hit,
  input  logic [ADDR_W-1:0] ack_addr,
  output logic [ADDR_W-1:0] ptr_q,
  output logic              pend_q
);
  logic ack_match;
  assign ack_match = ack_hit && (ack_addr == ptr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      pend_q <= 1'b0;
    end else if (post_hit) begin
      // completion wins over a simultaneous acknowledge
      ptr_q  <= post_addr;
      pend_q <= 1'b1;
    end else if (ack_match) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cmpl_irq_mask.sv
module cmpl_irq_mask #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [NUM_CH-1:0] bits,
  output logic [NUM_CH-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (set_we) begin
      mask_q <= mask_q | bits;
    end else if (clr_we) begin
      mask_q <= mask_q & ~bits;
    end
  end
endmodule

// File: rtl/cmpl_irq_regs.sv
module cmpl_irq_regs
  import cmpl_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 32,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic [REG_AW-1:0]             reg_addr,
  input  logic [NUM_CH-1:0]             mask,
  input  logic [NUM_CH-1:0]             raw,
  input  logic [NUM_CH-1:0][ADDR_W-1:0] ptrs,
  output logic [ADDR_W-1:0]             rdata
);
  logic [PTR_SEL_BIT-1:0] low;
  assign low = reg_addr[PTR_SEL_BIT-1:0];

  always_comb begin
    rdata = '0;
    if (reg_addr[PTR_SEL_BIT]) begin
      if (int'(low) < NUM_CH) rdata = ptrs[low[CH_W-1:0]];
    end else begin
      unique case (reg_addr)
        RA_MASK:   rdata[NUM_CH-1:0] = mask;
        RA_RAW:    rdata[NUM_CH-1:0] = raw;
        RA_MASKED: rdata[NUM_CH-1:0] = raw & mask;
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cmpl_irq_ctrl.sv
module cmpl_irq_ctrl
  import cmpl_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 32,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post_valid,
  output logic              post_ready,
  input  logic [CH_W-1:0]   post_chan,
  input  logic [ADDR_W-1:0] post_addr,
  input  logic              ack_valid,
  output logic              ack_ready,
  input  logic [CH_W-1:0]   ack_chan,
  input  logic [ADDR_W-1:0] ack_addr,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] irq,
  output logic              irq_any
);
  logic [NUM_CH-1:0]             pend_q;
  logic [NUM_CH-1:0]             mask_q;
  logic [NUM_CH-1:0][ADDR_W-1:0] ptr_q;
  logic                          post_fire, ack_fire;

  assign post_ready = rst_n;
  assign ack_ready  = rst_n;
  assign post_fire  = post_valid && post_ready;
  assign ack_fire   = ack_valid && ack_ready;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    cmpl_ptr_chan #(.ADDR_W(ADDR_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .post_hit (post_fire && (post_chan == CH_W'(i))),
      .post_addr(post_addr),
      .ack_hit  (ack_fire && (ack_chan == CH_W'(i))),
      .ack_addr (ack_addr),
      .ptr_q    (ptr_q[i]),
      .pend_q   (pend_q[i])
    );
  end

  cmpl_irq_mask #(.NUM_CH(NUM_CH)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .set_we(reg_wr && (reg_addr == RA_MASK_SET)),
    .clr_we(reg_wr && (reg_addr == RA_MASK_CLR)),
    .bits  (reg_wdata[NUM_CH-1:0]),
    .mask_q(mask_q)
  );

  cmpl_irq_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .reg_addr(reg_addr),
    .mask    (mask_q),
    .raw     (pend_q),
    .ptrs    (ptr_q),
    .rdata   (reg_rdata)
  );

  assign irq     = pend_q & mask_q;
  assign irq_any = |irq;
endmodule

// File: rtl/cmpl_irq_chk.sv
module cmpl_irq_chk
  import cmpl_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 32,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          post_valid,
  input logic                          post_ready,
  input logic [CH_W-1:0]               post_chan,
  input logic                          ack_valid,
  input logic                          ack_ready,
  input logic                          reg_wr,
  input logic [REG_AW-1:0]             reg_addr,
  input logic [ADDR_W-1:0]             reg_wdata,
  input logic [NUM_CH-1:0]             raw,
  input logic [NUM_CH-1:0]             mask,
  input logic [NUM_CH-1:0][ADDR_W-1:0] ptrs
);
  AST_POST_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid && post_ready) |=> raw[$past(post_chan)]); // R5

  AST_COLLIDE_POST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid && post_ready && ack_valid) |=> raw[$past(post_chan)]); // R8

  AST_IDLE_HOLDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (!post_valid && !ack_valid) |=> $stable(raw)); // R2

  AST_ACK_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    !post_valid |=> $stable(ptrs)); // R6

  AST_MASK_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_MASK_SET) |=>
      ((mask & $past(reg_wdata[NUM_CH-1:0])) == $past(reg_wdata[NUM_CH-1:0]))); // R3

  AST_MASK_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_MASK_CLR) |=>
      ((mask & $past(reg_wdata[NUM_CH-1:0])) == '0)); // R3

  AST_READY_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (post_ready && ack_ready)); // R10
endmodule

bind cmpl_irq_ctrl cmpl_irq_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .post_valid(post_valid),
  .post_ready(post_ready),
  .post_chan (post_chan),
  .ack_valid (ack_valid),
  .ack_ready (ack_ready),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .raw       (pend_q),
  .mask      (mask_q),
  .ptrs      (ptr_q)
);

// File: tb/cmpl_irq_ctrl_bench.sv
module cmpl_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        post_valid = 1'b0, ack_valid = 1'b0, reg_wr = 1'b0;
  logic        post_ready, ack_ready, irq_any;
  logic [2:0]  post_chan = '0, ack_chan = '0;
  logic [31:0] post_addr = '0, ack_addr = '0, reg_wdata = '0, reg_rdata;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  irq;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  cmpl_irq_ctrl u_cmpl_irq_ctrl (.*);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic post(input logic [2:0] c, input logic [31:0] a);
    @(negedge clk); post_valid = 1'b1; post_chan = c; post_addr = a;
    @(negedge clk); post_valid = 1'b0;
  endtask

  task automatic ack(input logic [2:0] c, input logic [31:0] a);
    @(negedge clk); ack_valid = 1'b1; ack_chan = c; ack_addr = a;
    @(negedge clk); ack_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {24'h0, irq}, 32'h0);
    check("R1 irq_any", {31'h0, irq_any}, 32'h0);
    rd(5'h02, d); check("R1 mask", d, 32'h0);
    rd(5'h03, d); check("R1 raw", d, 32'h0);
    rd(5'h17, d); check("R1 ptr7", d, 32'h0);
    check("R10 ready", {30'h0, post_ready, ack_ready}, 32'h3);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(5'h00, 32'hA5); rd(5'h02, d); check("R3 set", d, 32'hA5);
    wr(5'h01, 32'h05); rd(5'h02, d); check("R3 clear", d, 32'hA0);
    wr(5'h00, 32'h00); rd(5'h02, d); check("R3 zero set", d, 32'hA0);
    wr(5'h01, 32'h00); rd(5'h02, d); check("R3 zero clear", d, 32'hA0);
  endtask

  task automatic t_post();
    logic [31:0] d;
    post(3'd5, 32'h0000_1000);
    check("R9 irq5", {24'h0, irq}, 32'h20);
    check("R9 irq_any", {31'h0, irq_any}, 32'h1);
    rd(5'h15, d); check("R6 ptr5", d, 32'h0000_1000);
    post(3'd0, 32'h0);
    rd(5'h03, d); check("R5 raw zero addr", d, 32'h21);
    rd(5'h04, d); check("R4 masked", d, 32'h20);
    check("R9 irq0 masked off", {24'h0, irq}, 32'h20);
    post(3'd7, 32'hFFFF_FFFF);
    rd(5'h17, d); check("R5 ptr7", d, 32'hFFFF_FFFF);
    check("R9 irq7", {24'h0, irq}, 32'hA0);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    ack(3'd5, 32'h0000_1234);
    rd(5'h03, d); check("R2 mismatch keeps", d, 32'hA1);
    rd(5'h15, d); check("R6 ack no write", d, 32'h0000_1000);
    repeat (3) @(negedge clk);
    check("R2 level held", {24'h0, irq}, 32'hA0);
    ack(3'd5, 32'h0000_1000);
    rd(5'h03, d); check("R7 match clears", d, 32'h81);
    ack(3'd0, 32'h0); ack(3'd7, 32'hFFFF_FFFF);
    rd(5'h03, d); check("R7 edge channels", d, 32'h0);
  endtask

  task automatic t_multi();
    logic [31:0] d;
    post(3'd2, 32'h200); post(3'd2, 32'h300);
    ack(3'd2, 32'h200);
    rd(5'h03, d); check("R7 stale ack", d, 32'h04);
    ack(3'd2, 32'h300);
    rd(5'h03, d); check("R7 latest ack", d, 32'h00);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    post(3'd1, 32'h40);
    @(negedge clk);
    post_valid = 1'b1; post_chan = 3'd1; post_addr = 32'h80;
    ack_valid = 1'b1; ack_chan = 3'd1; ack_addr = 32'h40;
    @(negedge clk); post_valid = 1'b0; ack_valid = 1'b0;
    rd(5'h03, d); check("R8 stays pending", d, 32'h02);
    rd(5'h11, d); check("R8 new ptr", d, 32'h80);
  endtask

  task automatic t_mask_raw();
    logic [31:0] d;
    wr(5'h00, 32'h02);
    check("R9 irq1 on", {24'h0, irq}, 32'h02);
    wr(5'h01, 32'hFF);
    rd(5'h03, d); check("R9 raw kept", d, 32'h02);
    check("R9 irq off", {24'h0, irq}, 32'h0);
    check("R9 any off", {31'h0, irq_any}, 32'h0);
    wr(5'h00, 32'hFF);
    check("R9 irq back", {24'h0, irq}, 32'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset(); t_mask(); t_post(); t_ack(); t_multi(); t_collide(); t_mask_raw();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule